// File: doc/BRIEF.md
# Byte-Stream Network Register Block

This block is a slave register window that joins a 32-bit host register bus to a byte-wide network packet interface. Incoming frames arrive on a valid/ready byte stream with an end-of-frame flag. The block stores each frame in a local byte buffer and publishes its length. The host then drains the frame one byte per read of the receive data register, and the published length counts down as it does so.

To transmit, the host first writes a frame length and then writes that many bytes, one per bus write, using only the low byte. The block then sends the frame on an outgoing byte stream that also uses valid/ready/last. An interrupt register gathers transmit completion, receive availability and a software test bit, and these drive a single interrupt line. The window also holds a 64-bit identification constant, a busy flag and a constant interrupt-routing word.

The host bus uses single-cycle read and write strobes. `host_rdata` is registered: it takes the value of the addressed register at the clock edge that samples `host_rd`, and it holds that value until the next read.

Top module: `bytestream_nic`

## Requirements
- R1: Reads at offset 0x00 and 0x04 return the low and high words of the 64-bit identification constant. The constant is ASCII with its first character in the least significant byte, and its last character is a version digit. With the defaults, 0x00 reads 0x52545342 and 0x04 reads 0x314D4145.
- R2: Reads at unmapped offsets return 0, and writes to them have no effect. Writes to the read-only registers (identification, busy at 0x08, receive count at 0x0C, interrupt info at 0x18) are ignored.
- R3: Bit 0 of the busy register at 0x08 is 1 while a receive frame is being taken in, and from an accepted transmit length until the last transmit byte is accepted. It is 0 otherwise.
- R4: After a frame of N bytes (N no larger than RX_DEPTH) ends with `rx_last`, the receive count at 0x0C reads N. Each read of 0x1C returns the next byte in bits 7:0, with zeros above, and decrements the count. Once the count is 0, reads of 0x1C return 0 and change nothing.
- R5: A received frame with more than RX_DEPTH bytes is consumed up to its last byte and then discarded. The receive count stays 0 and the receive interrupt bit is not set.
- R6: `rx_ready` is low while the receive interrupt bit (bit 1 at 0x14) is set, and while a held frame still has bytes left to read.
- R7: Writing a length N in 1..TX_DEPTH to 0x10 and then N bytes to 0x20 produces a frame on `tx_data` in write order, with `tx_last` set only on the Nth byte. Offset 0x10 reads N until that byte is accepted and reads 0 afterwards. A length of 0 or above TX_DEPTH is ignored. Data writes while no length is pending are ignored.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R9: In the interrupt register at 0x14, bit 0 is set when a transmit frame completes and bit 1 is set when a received frame is published. Writing 1 to either bit clears it. A completion that happens in the same cycle as a clear of bit 0 leaves bit 0 set.
- R10: Writing a word with bit 31 set raises the test bit (bit 31 of 0x14). A read of 0x14 returns the bit and then clears it. Writing an all-zero word also clears it.
- R11: `irq` is high exactly when bit 0, bit 1 or bit 31 of 0x14 is set. Offset 0x18 reads the INFO_WORD parameter, which defaults to 0x00000005.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Byte offset within the 0x40 window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Network side takes the outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: the completion of a transmit frame, which sets bit 0, and a host write of 1 to bit 0, which clears it. The bench provokes this by first leaving bit 0 set from an earlier frame. It then loads a one-byte frame and holds `tx_ready` low. On a single edge it releases `tx_ready` and issues the clearing write. A later read of 0x14 must still show bit 0 set, and a second clearing write on its own must then empty it.

// File: rtl/bsn_pkg.sv
package bsn_pkg;
  localparam int CNT_W = 17;

  localparam logic [5:0] OFS_ID_LO   = 6'h00;
  localparam logic [5:0] OFS_ID_HI   = 6'h04;
  localparam logic [5:0] OFS_BUSY    = 6'h08;
  localparam logic [5:0] OFS_RX_CNT  = 6'h0C;
  localparam logic [5:0] OFS_TX_CNT  = 6'h10;
  localparam logic [5:0] OFS_IRQ     = 6'h14;
  localparam logic [5:0] OFS_INFO    = 6'h18;
  localparam logic [5:0] OFS_RX_DATA = 6'h1C;
  localparam logic [5:0] OFS_TX_DATA = 6'h20;

  typedef enum logic [2:0] {RX_IDLE, RX_TAKE, RX_DROP, RX_SETTLE, RX_HOLD} rx_state_t;
  typedef enum logic [1:0] {TX_IDLE, TX_FILL, TX_SEND} tx_state_t;
endpackage

// File: rtl/bsn_rx_path.sv
module bsn_rx_path import bsn_pkg::*; #(
  parameter int DEPTH = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             pend_i,
  input  logic             pop_i,
  output logic [7:0]       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             publish_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  rx_state_t        state;
  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [AW-1:0]    rd_addr_c;
  logic [AW-1:0]    wr_addr_c;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       head_q;
  logic             beat, room, store, pop_ok;

  assign in_ready  = ((state == RX_IDLE) && !pend_i) || (state == RX_TAKE) || (state == RX_DROP);
  assign beat      = in_valid && in_ready;
  assign room      = (wr_ptr != PW'(DEPTH));
  assign store     = beat && ((state == RX_IDLE) || ((state == RX_TAKE) && room));
  assign wr_addr_c = (state == RX_IDLE) ? '0 : wr_ptr[AW-1:0];
  assign pop_ok    = pop_i && (state == RX_HOLD);
  assign rd_addr_c = (state == RX_SETTLE) ? '0 : (pop_ok ? rd_ptr + AW'(1) : rd_ptr);

  always_ff @(posedge clk) begin
    if (store) mem[wr_addr_c] <= in_data;
    head_q <= mem[rd_addr_c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      case (state)
        RX_IDLE: if (beat) begin
          wr_ptr <= PW'(1);
          state  <= in_last ? RX_SETTLE : RX_TAKE;
        end
        RX_TAKE: if (beat) begin
          if (!room) state <= in_last ? RX_IDLE : RX_DROP;
          else begin
            wr_ptr <= wr_ptr + PW'(1);
            if (in_last) state <= RX_SETTLE;
          end
        end
        RX_DROP: if (beat && in_last) state <= RX_IDLE;
        RX_SETTLE: begin
          cnt_q  <= CNT_W'(wr_ptr);
          rd_ptr <= '0;
          state  <= RX_HOLD;
        end
        RX_HOLD: if (pop_ok) begin
          rd_ptr <= rd_ptr + AW'(1);
          cnt_q  <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign head_o    = head_q;
  assign count_o   = cnt_q;
  assign busy_o    = (state == RX_TAKE) || (state == RX_DROP) || (state == RX_SETTLE);
  assign publish_o = (state == RX_SETTLE);
endmodule

// File: rtl/bsn_tx_path.sv
module bsn_tx_path import bsn_pkg::*; #(
  parameter int DEPTH = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_wr_i,
  input  logic             byte_wr_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] len_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready
);
  localparam int AW = $clog2(DEPTH);

  tx_state_t        state;
  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] len_q, wr_ptr, rd_ptr;
  logic [7:0]       data_q;
  logic             v_q, last_q, len_ok, done;

  assign len_ok = (wdata_i != '0) && (wdata_i <= 32'(DEPTH));
  assign done   = (state == TX_SEND) && v_q && out_ready && last_q;

  always_ff @(posedge clk) begin
    if ((state == TX_FILL) && byte_wr_i) mem[wr_ptr[AW-1:0]] <= wdata_i[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      len_q  <= '0;
      wr_ptr <= '0;
    end else begin
      case (state)
        TX_IDLE: if (len_wr_i && len_ok) begin
          len_q  <= wdata_i[CNT_W-1:0];
          wr_ptr <= '0;
          state  <= TX_FILL;
        end
        TX_FILL: if (byte_wr_i) begin
          wr_ptr <= wr_ptr + CNT_W'(1);
          if (wr_ptr == len_q - CNT_W'(1)) state <= TX_SEND;
        end
        TX_SEND: if (done) state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      last_q <= 1'b0;
      rd_ptr <= '0;
    end else if (state != TX_SEND) begin
      rd_ptr <= '0;
    end else if (done) begin
      v_q    <= 1'b0;
      last_q <= 1'b0;
    end else if ((!v_q || out_ready) && (rd_ptr != len_q)) begin
      data_q <= mem[rd_ptr[AW-1:0]];
      v_q    <= 1'b1;
      last_q <= (rd_ptr == len_q - CNT_W'(1));
      rd_ptr <= rd_ptr + CNT_W'(1);
    end
  end

  assign len_o     = (state == TX_IDLE) ? '0 : len_q;
  assign busy_o    = (state != TX_IDLE);
  assign done_o    = done;
  assign out_valid = v_q;
  assign out_data  = data_q;
  assign out_last  = last_q;
endmodule

// File: rtl/bsn_irq.sv
module bsn_irq (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  input  logic        tx_set_i,
  input  logic        rx_set_i,
  output logic [2:0]  bits_o,
  output logic        irq_o
);
  logic tx_q, rx_q, test_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      test_q <= 1'b0;
    end else begin
      if (tx_set_i) tx_q <= 1'b1;
      else if (wr_i && wdata_i[0]) tx_q <= 1'b0;

      if (rx_set_i) rx_q <= 1'b1;
      else if (wr_i && wdata_i[1]) rx_q <= 1'b0;

      if (wr_i && wdata_i[31]) test_q <= 1'b1;
      else if (wr_i && (wdata_i == '0)) test_q <= 1'b0;
      else if (rd_i) test_q <= 1'b0;
    end
  end

  assign bits_o = {test_q, rx_q, tx_q};
  assign irq_o  = tx_q | rx_q | test_q;
endmodule

// File: rtl/bytestream_nic.sv
module bytestream_nic import bsn_pkg::*; #(
  parameter int          RX_DEPTH  = 2048,
  parameter int          TX_DEPTH  = 2048,
  parameter logic [63:0] DEV_ID    = 64'h314D_4145_5254_5342,
  parameter logic [31:0] INFO_WORD = 32'h0000_0005
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [5:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  logic             rx_pop, irq_wr, irq_rd, txlen_wr, txbyte_wr;
  logic [7:0]       rx_head;
  logic [CNT_W-1:0] rx_cnt, tx_len;
  logic             rx_busy, tx_busy, rx_publish, tx_done, busy_c;
  logic [2:0]       irq_bits;
  logic [31:0]      rdata_q;

  assign rx_pop    = host_rd && (host_addr == OFS_RX_DATA);
  assign irq_rd    = host_rd && (host_addr == OFS_IRQ);
  assign irq_wr    = host_wr && (host_addr == OFS_IRQ);
  assign txlen_wr  = host_wr && (host_addr == OFS_TX_CNT);
  assign txbyte_wr = host_wr && (host_addr == OFS_TX_DATA);
  assign busy_c    = rx_busy || tx_busy;

  bsn_rx_path #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst(rst),
    .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last), .in_ready(rx_ready),
    .pend_i(irq_bits[1]), .pop_i(rx_pop),
    .head_o(rx_head), .count_o(rx_cnt), .busy_o(rx_busy), .publish_o(rx_publish)
  );

  bsn_tx_path #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst(rst),
    .len_wr_i(txlen_wr), .byte_wr_i(txbyte_wr), .wdata_i(host_wdata),
    .len_o(tx_len), .busy_o(tx_busy), .done_o(tx_done),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last), .out_ready(tx_ready)
  );

  bsn_irq u_irq (
    .clk(clk), .rst(rst),
    .wr_i(irq_wr), .rd_i(irq_rd), .wdata_i(host_wdata),
    .tx_set_i(tx_done), .rx_set_i(rx_publish),
    .bits_o(irq_bits), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (host_rd) begin
      case (host_addr)
        OFS_ID_LO:   rdata_q <= DEV_ID[31:0];
        OFS_ID_HI:   rdata_q <= DEV_ID[63:32];
        OFS_BUSY:    rdata_q <= {31'b0, busy_c};
        OFS_RX_CNT:  rdata_q <= 32'(rx_cnt);
        OFS_TX_CNT:  rdata_q <= 32'(tx_len);
        OFS_IRQ:     rdata_q <= {irq_bits[2], 29'b0, irq_bits[1:0]};
        OFS_INFO:    rdata_q <= INFO_WORD;
        OFS_RX_DATA: rdata_q <= (rx_cnt != '0) ? {24'b0, rx_head} : 32'b0;
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/bsn_checker.sv
module bsn_checker import bsn_pkg::*; #(
  parameter int RX_DEPTH = 2048
) (
  input logic             clk,
  input logic             rst,
  input logic             host_rd,
  input logic             host_wr,
  input logic [5:0]       host_addr,
  input logic [31:0]      host_wdata,
  input logic             rx_ready,
  input logic             rx_pend,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             tx_ready,
  input logic             busy,
  input logic             irq
);
  assert_ready_held_R6: assert property (@(posedge clk) disable iff (rst)
    rx_pend |-> !rx_ready);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CNT_W'(RX_DEPTH));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && (host_addr == OFS_RX_DATA) && (rx_cnt != '0)) |=> (rx_cnt == $past(rx_cnt) - CNT_W'(1)));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_test_raise_R10: assert property (@(posedge clk) disable iff (rst)
    (host_wr && (host_addr == OFS_IRQ) && host_wdata[31]) |=> irq);

  assert_tx_busy_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);
endmodule

bind bytestream_nic bsn_checker #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .rx_ready(rx_ready), .rx_pend(irq_bits[1]), .rx_cnt(rx_cnt),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
  .busy(busy_c), .irq(irq)
);

// File: tb/bytestream_nic_tb.sv
module bytestream_nic_tb;
  import bsn_pkg::*;
  localparam int RXD = 16;
  localparam int TXD = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, host_rd, host_wr, rx_valid, rx_last, rx_ready;
  logic        tx_valid, tx_last, tx_ready, irq;
  logic [5:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [7:0]  rx_data, tx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  bytestream_nic #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [5:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic host_read(input logic [5:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic read_expect(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    host_read(a, v);
    check(req, v, exp);
  endtask

  task automatic rx_frame(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1; rx_data = base + 8'(i); rx_last = (i == n - 1);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic tx_collect(input string req, input int n, input logic [7:0] base);
    int k = 0;
    int guard = 0;
    tx_ready = 1'b1;
    while (k < n && guard < 1000) begin
      if (tx_valid) begin
        check(req, {24'b0, tx_data}, {24'b0, base + 8'(k)});
        check(req, {31'b0, tx_last}, {31'b0, (k == n - 1)});
        k++;
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(req, k, n);
  endtask

  task automatic tx_load(input int n, input logic [7:0] base);
    host_write(OFS_TX_CNT, n);
    for (int i = 0; i < n; i++) host_write(OFS_TX_DATA, 32'hFFFF_FF00 | 32'(base + 8'(i)));
  endtask

  task automatic t_reset_state;
    check("R11 reset irq", {31'b0, irq}, 0);
    check("R6 reset rx_ready", {31'b0, rx_ready}, 1);
    check("R8 reset tx_valid", {31'b0, tx_valid}, 0);
    check("R1 reset rdata", host_rdata, 0);
    read_expect("R3 busy idle", OFS_BUSY, 0);
  endtask

  task automatic t_ident;
    read_expect("R1 id low", OFS_ID_LO, 32'h5254_5342);
    read_expect("R1 id high", OFS_ID_HI, 32'h314D_4145);
    read_expect("R11 info", OFS_INFO, 32'h0000_0005);
  endtask

  task automatic t_unmapped;
    host_write(6'h24, 32'hFFFF_FFFF);
    read_expect("R2 unmapped 0x24", 6'h24, 0);
    read_expect("R2 unmapped 0x3C", 6'h3C, 0);
    host_write(OFS_BUSY, 32'h1);
    read_expect("R2 busy write ignored", OFS_BUSY, 0);
    host_write(OFS_RX_CNT, 32'h5);
    read_expect("R2 rx count write ignored", OFS_RX_CNT, 0);
    host_write(OFS_ID_LO, 32'h0);
    read_expect("R2 id write ignored", OFS_ID_LO, 32'h5254_5342);
  endtask

  task automatic t_rx_basic;
    rx_frame(5, 8'h10);
    read_expect("R4 rx count", OFS_RX_CNT, 5);
    check("R6 ready low while held", {31'b0, rx_ready}, 0);
    check("R11 irq on rx", {31'b0, irq}, 1);
    read_expect("R9 rx bit set", OFS_IRQ, 32'h2);
    read_expect("R4 byte 0", OFS_RX_DATA, 32'h10);
    read_expect("R4 byte 1", OFS_RX_DATA, 32'h11);
    read_expect("R4 count after two", OFS_RX_CNT, 3);
    read_expect("R4 byte 2", OFS_RX_DATA, 32'h12);
    read_expect("R4 byte 3", OFS_RX_DATA, 32'h13);
    read_expect("R4 byte 4", OFS_RX_DATA, 32'h14);
    read_expect("R4 count drained", OFS_RX_CNT, 0);
    read_expect("R4 read past end", OFS_RX_DATA, 0);
    check("R6 ready low while bit1 set", {31'b0, rx_ready}, 0);
    host_write(OFS_IRQ, 32'h2);
    check("R9 clear rx bit reopens", {31'b0, rx_ready}, 1);
    check("R11 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_rx_busy;
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h60; rx_last = 1'b0;
    @(negedge clk);
    rx_valid = 1'b0;
    read_expect("R3 busy mid receive", OFS_BUSY, 1);
    rx_valid = 1'b1; rx_data = 8'h61; rx_last = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
    read_expect("R3 busy after receive", OFS_BUSY, 0);
    read_expect("R4 two-byte count", OFS_RX_CNT, 2);
    read_expect("R4 two-byte first", OFS_RX_DATA, 32'h60);
    read_expect("R4 two-byte second", OFS_RX_DATA, 32'h61);
    host_write(OFS_IRQ, 32'h2);
  endtask

  task automatic t_rx_limits;
    logic [31:0] v;
    rx_frame(RXD, 8'h40);
    read_expect("R4 full-depth count", OFS_RX_CNT, RXD);
    read_expect("R4 full-depth first", OFS_RX_DATA, 32'h40);
    for (int i = 1; i < RXD - 1; i++) host_read(OFS_RX_DATA, v);
    read_expect("R4 full-depth last", OFS_RX_DATA, 32'h4F);
    host_write(OFS_IRQ, 32'h2);
    rx_frame(RXD + 4, 8'h80);
    read_expect("R5 oversize count", OFS_RX_CNT, 0);
    read_expect("R5 oversize no irq bit", OFS_IRQ, 0);
    check("R5 ready after drop", {31'b0, rx_ready}, 1);
  endtask

  task automatic t_tx_basic;
    host_write(OFS_TX_CNT, 4);
    read_expect("R7 tx count pending", OFS_TX_CNT, 4);
    read_expect("R3 busy during fill", OFS_BUSY, 1);
    for (int i = 0; i < 4; i++) host_write(OFS_TX_DATA, 32'hFFFF_FF00 | 32'(8'hA0 + 8'(i)));
    tx_collect("R7 tx frame", 4, 8'hA0);
    read_expect("R7 tx count cleared", OFS_TX_CNT, 0);
    read_expect("R3 busy after send", OFS_BUSY, 0);
    read_expect("R9 tx bit set", OFS_IRQ, 1);
    check("R11 irq on tx", {31'b0, irq}, 1);
  endtask

  task automatic t_tx_ignored;
    host_write(OFS_TX_CNT, 0);
    read_expect("R7 zero length ignored", OFS_TX_CNT, 0);
    host_write(OFS_TX_CNT, TXD + 1);
    read_expect("R7 oversize length ignored", OFS_TX_CNT, 0);
    host_write(OFS_TX_DATA, 32'h55);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 stray data no frame", {31'b0, tx_valid}, 0);
    tx_ready = 1'b0;
    read_expect("R7 stray data idle", OFS_BUSY, 0);
  endtask

  task automatic t_tx_stall;
    int guard = 0;
    tx_load(2, 8'h31);
    while (!tx_valid && guard < 100) begin guard++; @(negedge clk); end
    repeat (5) @(negedge clk);
    check("R8 valid held", {31'b0, tx_valid}, 1);
    check("R8 data held", {24'b0, tx_data}, 32'h31);
    tx_collect("R8 frame after stall", 2, 8'h31);
  endtask

  task automatic t_same_cycle;
    int guard = 0;
    read_expect("R9 bit0 before", OFS_IRQ, 1);
    tx_load(1, 8'hAB);
    while (!tx_valid && guard < 100) begin guard++; @(negedge clk); end
    tx_ready = 1'b1;
    host_wr = 1'b1; host_addr = OFS_IRQ; host_wdata = 32'h1;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0; tx_ready = 1'b0;
    check("R9 frame left", {31'b0, tx_valid}, 0);
    read_expect("R9 set wins over clear", OFS_IRQ, 1);
    host_write(OFS_IRQ, 32'h1);
    read_expect("R9 clear alone", OFS_IRQ, 0);
  endtask

  task automatic t_test_bit;
    host_write(OFS_IRQ, 32'h3);
    host_write(OFS_IRQ, 32'h8000_0000);
    check("R10 test raises irq", {31'b0, irq}, 1);
    read_expect("R10 read shows test", OFS_IRQ, 32'h8000_0000);
    read_expect("R10 read cleared test", OFS_IRQ, 0);
    check("R11 irq low after test", {31'b0, irq}, 0);
    host_write(OFS_IRQ, 32'h8000_0000);
    host_write(OFS_IRQ, 32'h1);
    check("R10 nonzero write keeps test", {31'b0, irq}, 1);
    host_write(OFS_IRQ, 32'h0);
    check("R10 zero write clears", {31'b0, irq}, 0);
    read_expect("R10 register empty", OFS_IRQ, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; host_rd = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; tx_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_ident();
    t_unmapped();
    t_rx_basic();
    t_rx_busy();
    t_rx_limits();
    t_tx_basic();
    t_tx_ignored();
    t_tx_stall();
    t_same_cycle();
    t_test_bit();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule